// File: doc/BRIEF.md
# Set-Associative Address Translation Cache with Software Refill

This block turns a 40-bit virtual address into a 36-bit physical address for 16 KB pages. It holds 512 translations as 256 sets of two ways. A lookup presents a virtual address and an access kind (read or write). One clock later the block returns one of three results: a translation, a miss that software must service, or a protection fault. The block never reads page tables itself. Any refill is written by the operating system through a separate write port, which loads a whole entry into a chosen set and way.

Each entry carries the following fields:
- a valid flag;
- a dirty flag, set by permitted writes;
- a reference flag, set by permitted hits, which software can clear across the whole array in one cycle;
- a 2-bit rights field;
- an 18-bit tag;
- a 22-bit physical page number.

Each set also keeps a one-bit least-recently-used pointer. Every response carries a suggested victim way for the looked-up set, so software knows where to place the next refill. A global invalidate input, and reset, drop every translation.

Top module: `tlbx_top`

## Requirements
- R1: Bits 21:14 of the lookup address select the set and bits 39:22 are compared with the stored tag. The response appears on the outputs exactly one clock after `lk_valid`, with `rsp_valid` high for that one cycle.
- R2: On a permitted hit, `rsp_hit` is 1 and `rsp_pa` equals the stored page number concatenated with lookup address bits 13:0.
- R3: A way matches only if its valid flag is set and its tag is equal. With no match, `rsp_miss` is 1, `rsp_pa` is 0, and no dirty, reference or LRU state changes.
- R4: Rights bit 0 grants reads and bit 1 grants writes. When a matching entry does not grant the access, `rsp_fault` is 1 and `rsp_pa` is 0. Dirty, reference and LRU state are left unchanged.
- R5: A permitted write hit sets the entry's dirty flag. `rsp_dirty` reports the matching entry's dirty flag as it was before the lookup, or 0 on a miss.
- R6: Reference flags:
  - A permitted hit sets the entry's reference flag.
  - `os_clr_ref` clears every reference flag; a permitted hit in the same cycle still leaves its own flag set.
  - An OS write clears the written entry's flag.
  - `rsp_ref` reports the flag as it was before the lookup.
- R7: When `rsp_valid` is 1, exactly one of `rsp_hit`, `rsp_miss` and `rsp_fault` is 1. Otherwise all three are 0.
- R8: Each set's LRU pointer is 0 after reset. A permitted hit to way w sets it to the other way. OS writes and invalidates leave it unchanged.
- R9: `rsp_victim` is computed from the looked-up set's state before the lookup, using the first rule that applies:
  - the lowest-numbered invalid way;
  - the only way whose reference flag is clear, if exactly one is;
  - the LRU pointer.
- R10: `inv_all` clears every valid flag at the next edge and takes precedence over an OS write in the same cycle. Reset clears every valid, dirty and reference flag.
- R11: An OS write and a lookup in the same cycle: the lookup sees the old contents, and the written values replace any update made by the lookup.
- R12: `rsp_way` gives the matching way on a hit or fault, and 0 on a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_all | input | 1 | Invalidate every entry |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | 40 | Lookup virtual address |
| lk_wr | input | 1 | Access kind: 1 write, 0 read |
| os_we | input | 1 | OS entry write strobe |
| os_set | input | 8 | Set to write |
| os_way | input | 1 | Way to write |
| os_vld | input | 1 | Valid flag to store |
| os_dirty | input | 1 | Dirty flag to store |
| os_rights | input | 2 | Rights to store (bit0 read, bit1 write) |
| os_tag | input | 18 | Tag to store |
| os_ppn | input | 22 | Physical page number to store |
| os_clr_ref | input | 1 | Clear all reference flags |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Permitted translation |
| rsp_miss | output | 1 | No matching entry, software trap |
| rsp_fault | output | 1 | Access not permitted |
| rsp_pa | output | 36 | Physical address, 0 unless hit |
| rsp_way | output | 1 | Matching way |
| rsp_dirty | output | 1 | Matching entry's dirty flag before lookup |
| rsp_ref | output | 1 | Matching entry's reference flag before lookup |
| rsp_victim | output | 1 | Suggested refill way for the looked-up set |

## Verification
The embedded properties assume that software never leaves two valid entries with the same tag in one set. Under that assumption, a lookup selects at most one way.

The stimulus enforces this rule in its random phase: every tag written to way w has its lowest bit equal to w, so the two ways of a set can never hold equal tags.

The properties also assume that `inv_all` is low while reset is asserted. The bench holds all control strobes low during reset.

// File: rtl/tlbx_pkg.sv
package tlbx_pkg;
   localparam int RIGHTS_W = 2;
   localparam int RIGHT_RD = 0;
   localparam int RIGHT_WR = 1;

   typedef enum logic {
      ACC_READ  = 1'b0,
      ACC_WRITE = 1'b1
   } acc_kind_e;

   function automatic logic access_ok(input logic [RIGHTS_W-1:0] rights,
                                      input acc_kind_e kind);
      return (kind == ACC_WRITE) ? rights[RIGHT_WR] : rights[RIGHT_RD];
   endfunction
endpackage

// File: rtl/tlbx_way.sv
module tlbx_way #(
   parameter int SETS   = 256,
   parameter int TAG_W  = 18,
   parameter int PPN_W  = 22,
   parameter int RGT_W  = 2,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inv_all,
   input  logic             clr_ref,
   input  logic [IDX_W-1:0] rd_set,
   input  logic             touch,
   input  logic             touch_dirty,
   input  logic             os_we,
   input  logic [IDX_W-1:0] os_set,
   input  logic             os_vld,
   input  logic             os_dirty,
   input  logic [RGT_W-1:0] os_rights,
   input  logic [TAG_W-1:0] os_tag,
   input  logic [PPN_W-1:0] os_ppn,
   output logic             e_vld,
   output logic             e_dirty,
   output logic             e_ref,
   output logic [RGT_W-1:0] e_rights,
   output logic [TAG_W-1:0] e_tag,
   output logic [PPN_W-1:0] e_ppn
);
   logic [SETS-1:0]  vld_q;
   logic [SETS-1:0]  dirty_q;
   logic [SETS-1:0]  ref_q;
   logic [TAG_W-1:0] tag_q   [SETS];
   logic [PPN_W-1:0] ppn_q   [SETS];
   logic [RGT_W-1:0] rgt_q   [SETS];

   // flag state: lookup effects first, OS write after, invalidate last
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q   <= '0;
         dirty_q <= '0;
         ref_q   <= '0;
      end else begin
         if (clr_ref) ref_q <= '0;
         if (touch) begin
            ref_q[rd_set] <= 1'b1;
            if (touch_dirty) dirty_q[rd_set] <= 1'b1;
         end
         if (os_we) begin
            vld_q[os_set]   <= os_vld;
            dirty_q[os_set] <= os_dirty;
            ref_q[os_set]   <= 1'b0;
         end
         if (inv_all) vld_q <= '0;
      end
   end

   always_ff @(posedge clk) begin
      if (os_we) begin
         tag_q[os_set] <= os_tag;
         ppn_q[os_set] <= os_ppn;
         rgt_q[os_set] <= os_rights;
      end
   end

   assign e_vld    = vld_q[rd_set];
   assign e_dirty  = dirty_q[rd_set];
   assign e_ref    = ref_q[rd_set];
   assign e_tag    = tag_q[rd_set];
   assign e_ppn    = ppn_q[rd_set];
   assign e_rights = rgt_q[rd_set];

   assert_inv_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $past(inv_all) |-> (vld_q == '0));

   assert_write_dirty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(touch && touch_dirty && !(os_we && os_set == rd_set))
      |-> dirty_q[$past(rd_set)]);

   assert_touch_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(touch && !(os_we && os_set == rd_set)) |-> ref_q[$past(rd_set)]);
endmodule

// File: rtl/tlbx_victim.sv
module tlbx_victim #(
   parameter int WAYS   = 2,
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic [WAYS-1:0]  vld,
   input  logic [WAYS-1:0]  refb,
   input  logic [WAY_W-1:0] lru_way,
   output logic [WAY_W-1:0] victim
);
   logic             any_inv;
   logic [WAY_W-1:0] first_inv;
   logic [WAY_W-1:0] clear_way;

   always_comb begin
      any_inv   = 1'b0;
      first_inv = '0;
      for (int i = WAYS - 1; i >= 0; i--) begin
         if (!vld[i]) begin
            any_inv   = 1'b1;
            first_inv = WAY_W'(i);
         end
      end
      clear_way = '0;
      for (int i = 0; i < WAYS; i++) begin
         if (!refb[i]) clear_way = WAY_W'(i);
      end
      if (any_inv)                       victim = first_inv;
      else if ($countones(~refb) == 1)   victim = clear_way;
      else                               victim = lru_way;
   end
endmodule

// File: rtl/tlbx_top.sv
module tlbx_top
   import tlbx_pkg::*;
#(
   parameter int VA_W  = 40,
   parameter int PA_W  = 36,
   parameter int OFS_W = 14,
   parameter int SETS  = 256,
   parameter int WAYS  = 2,
   localparam int IDX_W = $clog2(SETS),
   localparam int TAG_W = VA_W - OFS_W - IDX_W,
   localparam int PPN_W = PA_W - OFS_W,
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inv_all,
   input  logic             lk_valid,
   input  logic [VA_W-1:0]  lk_va,
   input  logic             lk_wr,
   input  logic             os_we,
   input  logic [IDX_W-1:0] os_set,
   input  logic [WAY_W-1:0] os_way,
   input  logic             os_vld,
   input  logic             os_dirty,
   input  logic [RIGHTS_W-1:0] os_rights,
   input  logic [TAG_W-1:0] os_tag,
   input  logic [PPN_W-1:0] os_ppn,
   input  logic             os_clr_ref,
   output logic             rsp_valid,
   output logic             rsp_hit,
   output logic             rsp_miss,
   output logic             rsp_fault,
   output logic [PA_W-1:0]  rsp_pa,
   output logic [WAY_W-1:0] rsp_way,
   output logic             rsp_dirty,
   output logic             rsp_ref,
   output logic [WAY_W-1:0] rsp_victim
);
   if (WAYS != 2) begin : g_bad_ways
      $error("tlbx_top: one-bit LRU pointer needs exactly two ways");
   end
   if ((1 << IDX_W) != SETS) begin : g_bad_sets
      $error("tlbx_top: SETS must be a power of two");
   end
   if (TAG_W < 1 || PPN_W < 1) begin : g_bad_widths
      $error("tlbx_top: address widths leave no tag or page number");
   end

   logic [IDX_W-1:0] set_idx;
   logic [TAG_W-1:0] tag_in;
   logic [OFS_W-1:0] ofs_in;

   assign ofs_in  = lk_va[OFS_W-1:0];
   assign set_idx = lk_va[OFS_W +: IDX_W];
   assign tag_in  = lk_va[VA_W-1 -: TAG_W];

   logic [WAYS-1:0]     e_vld, e_dirty, e_ref, match, touch;
   logic [RIGHTS_W-1:0] e_rights [WAYS];
   logic [TAG_W-1:0]    e_tag    [WAYS];
   logic [PPN_W-1:0]    e_ppn    [WAYS];

   logic                hit_any, perm, ok;
   logic [WAY_W-1:0]    hw;
   logic [RIGHTS_W-1:0] sel_rights;
   logic [PPN_W-1:0]    sel_ppn;
   logic                sel_dirty, sel_ref;

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign match[w] = e_vld[w] && (e_tag[w] == tag_in);
      assign touch[w] = ok && match[w];

      tlbx_way #(
         .SETS (SETS),
         .TAG_W(TAG_W),
         .PPN_W(PPN_W),
         .RGT_W(RIGHTS_W)
      ) u_way (
         .clk        (clk),
         .rst_n      (rst_n),
         .inv_all    (inv_all),
         .clr_ref    (os_clr_ref),
         .rd_set     (set_idx),
         .touch      (touch[w]),
         .touch_dirty(lk_wr),
         .os_we      (os_we && (os_way == WAY_W'(w))),
         .os_set     (os_set),
         .os_vld     (os_vld),
         .os_dirty   (os_dirty),
         .os_rights  (os_rights),
         .os_tag     (os_tag),
         .os_ppn     (os_ppn),
         .e_vld      (e_vld[w]),
         .e_dirty    (e_dirty[w]),
         .e_ref      (e_ref[w]),
         .e_rights   (e_rights[w]),
         .e_tag      (e_tag[w]),
         .e_ppn      (e_ppn[w])
      );
   end

   always_comb begin
      hw         = '0;
      sel_rights = '0;
      sel_ppn    = '0;
      sel_dirty  = 1'b0;
      sel_ref    = 1'b0;
      for (int w = 0; w < WAYS; w++) begin
         if (match[w]) begin
            hw         = WAY_W'(w);
            sel_rights = e_rights[w];
            sel_ppn    = e_ppn[w];
            sel_dirty  = e_dirty[w];
            sel_ref    = e_ref[w];
         end
      end
   end

   assign hit_any = |match;
   assign perm    = access_ok(sel_rights, acc_kind_e'(lk_wr));
   assign ok      = lk_valid && hit_any && perm;

   // one-bit LRU pointer per set, names the least recently used way
   logic [SETS-1:0]  lru_q;
   logic [WAY_W-1:0] victim_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  lru_q <= '0;
      else if (ok) lru_q[set_idx] <= ~hw[0];
   end

   tlbx_victim #(.WAYS(WAYS)) u_victim (
      .vld    (e_vld),
      .refb   (e_ref),
      .lru_way(WAY_W'(lru_q[set_idx])),
      .victim (victim_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid  <= 1'b0;
         rsp_hit    <= 1'b0;
         rsp_miss   <= 1'b0;
         rsp_fault  <= 1'b0;
         rsp_pa     <= '0;
         rsp_way    <= '0;
         rsp_dirty  <= 1'b0;
         rsp_ref    <= 1'b0;
         rsp_victim <= '0;
      end else begin
         rsp_valid  <= lk_valid;
         rsp_hit    <= ok;
         rsp_miss   <= lk_valid && !hit_any;
         rsp_fault  <= lk_valid && hit_any && !perm;
         rsp_pa     <= ok ? {sel_ppn, ofs_in} : '0;
         rsp_way    <= (lk_valid && hit_any) ? hw : '0;
         rsp_dirty  <= lk_valid && hit_any && sel_dirty;
         rsp_ref    <= lk_valid && hit_any && sel_ref;
         rsp_victim <= victim_c;
      end
   end

   assert_one_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1));

   assert_quiet_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_fault));

   assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> (rsp_pa[OFS_W-1:0] == $past(ofs_in)));

   assert_fault_no_pa_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_fault || rsp_miss) |-> (rsp_pa == '0));

   assert_unique_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |-> ($countones(match) <= 1));

   assert_lru_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ok) |-> (lru_q[$past(set_idx)] != $past(hw[0])));
endmodule

// File: tb/tb_tlbx_top.sv
module tb_tlbx_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        inv_all = 1'b0;
   logic        lk_valid = 1'b0;
   logic [39:0] lk_va = '0;
   logic        lk_wr = 1'b0;
   logic        os_we = 1'b0;
   logic [7:0]  os_set = '0;
   logic        os_way = 1'b0;
   logic        os_vld = 1'b0;
   logic        os_dirty = 1'b0;
   logic [1:0]  os_rights = '0;
   logic [17:0] os_tag = '0;
   logic [21:0] os_ppn = '0;
   logic        os_clr_ref = 1'b0;
   logic        rsp_valid, rsp_hit, rsp_miss, rsp_fault;
   logic [35:0] rsp_pa;
   logic        rsp_way, rsp_dirty, rsp_ref, rsp_victim;

   always #5 clk = ~clk;

   tlbx_top dut (
      .clk(clk), .rst_n(rst_n), .inv_all(inv_all), .lk_valid(lk_valid),
      .lk_va(lk_va), .lk_wr(lk_wr), .os_we(os_we), .os_set(os_set),
      .os_way(os_way), .os_vld(os_vld), .os_dirty(os_dirty),
      .os_rights(os_rights), .os_tag(os_tag), .os_ppn(os_ppn),
      .os_clr_ref(os_clr_ref), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
      .rsp_miss(rsp_miss), .rsp_fault(rsp_fault), .rsp_pa(rsp_pa),
      .rsp_way(rsp_way), .rsp_dirty(rsp_dirty), .rsp_ref(rsp_ref),
      .rsp_victim(rsp_victim)
   );

   // behavioural reference state
   bit          mv [256][2];
   bit          md [256][2];
   bit          mr [256][2];
   logic [17:0] mt [256][2];
   logic [21:0] mp [256][2];
   logic [1:0]  mg [256][2];
   bit          ml [256];

   int checks = 0;
   int errs   = 0;
   bit done   = 0;

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // one clock with the inputs currently driven; compare the response after it
   task automatic cyc(string sc);
      int s, hw, hits;
      bit ok, flt, perm;
      logic [17:0] t;
      logic [35:0] e_pa;
      bit e_dirty, e_ref, e_vic;
      s = int'(lk_va[21:14]);
      t = lk_va[39:22];
      hits = 0; hw = 0;
      for (int w = 0; w < 2; w++) if (mv[s][w] && mt[s][w] == t) begin hits++; hw = w; end
      perm = lk_wr ? mg[s][hw][1] : mg[s][hw][0];
      ok   = lk_valid && hits > 0 && perm;
      flt  = lk_valid && hits > 0 && !perm;
      e_pa    = ok ? {mp[s][hw], lk_va[13:0]} : 36'd0;
      e_dirty = lk_valid && hits > 0 && md[s][hw];
      e_ref   = lk_valid && hits > 0 && mr[s][hw];
      if (!mv[s][0]) e_vic = 0;
      else if (!mv[s][1]) e_vic = 1;
      else if (mr[s][0] != mr[s][1]) e_vic = mr[s][0];
      else e_vic = ml[s];
      @(posedge clk);
      if (os_clr_ref) foreach (mr[i, j]) mr[i][j] = 0;
      if (ok) begin
         mr[s][hw] = 1;
         if (lk_wr) md[s][hw] = 1;
         ml[s] = (hw == 0);
      end
      if (os_we) begin
         mv[os_set][os_way] = os_vld;  md[os_set][os_way] = os_dirty;
         mr[os_set][os_way] = 0;       mt[os_set][os_way] = os_tag;
         mp[os_set][os_way] = os_ppn;  mg[os_set][os_way] = os_rights;
      end
      if (inv_all) foreach (mv[i, j]) mv[i][j] = 0;
      @(negedge clk);
      chk({"R1 ", sc}, "valid", 64'(rsp_valid), 64'(lk_valid));
      chk({"R7 ", sc}, "hit", 64'(rsp_hit), 64'(ok));
      chk({"R3 ", sc}, "miss", 64'(rsp_miss), 64'(lk_valid && hits == 0));
      chk({"R4 ", sc}, "fault", 64'(rsp_fault), 64'(flt));
      chk({"R2 ", sc}, "pa", 64'(rsp_pa), 64'(e_pa));
      if (lk_valid) begin
         chk({"R5 ", sc}, "dirty", 64'(rsp_dirty), 64'(e_dirty));
         chk({"R6 ", sc}, "ref", 64'(rsp_ref), 64'(e_ref));
         chk({"R12 ", sc}, "way", 64'(rsp_way), 64'((hits > 0) ? hw : 0));
         chk({"R9 ", sc}, "victim", 64'(rsp_victim), 64'(e_vic));
      end
      lk_valid = 0; os_we = 0; os_clr_ref = 0; inv_all = 0;
   endtask

   function automatic logic [39:0] va(logic [17:0] t, logic [7:0] s, logic [13:0] o);
      return {t, s, o};
   endfunction

   task automatic look(logic [39:0] a, bit wr, string sc);
      lk_valid = 1; lk_va = a; lk_wr = wr;
      cyc(sc);
   endtask

   task automatic wr_entry(int s, bit w, bit v, bit d, logic [1:0] g,
                           logic [17:0] t, logic [21:0] p);
      os_we = 1; os_set = 8'(s); os_way = w; os_vld = v; os_dirty = d;
      os_rights = g; os_tag = t; os_ppn = p;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errs++;
         $display("FAIL watchdog expired: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 reset", "valid", 64'(rsp_valid), 64'd0);
      rst_n = 1;
      @(negedge clk);
      // R3: empty array misses everywhere
      look(va(18'h1, 8'h5, 14'h12), 0, "empty miss");
      look(va(18'h3ffff, 8'hff, 14'h3fff), 1, "empty miss hi");
      // load set 5: way0 read-only, way1 read/write
      wr_entry(5, 0, 1, 0, 2'b01, 18'h0A, 22'h12345); cyc("load w0");
      wr_entry(5, 1, 1, 0, 2'b11, 18'h0B, 22'h3ABCD); cyc("load w1");
      look(va(18'h0A, 8'h5, 14'h1234), 0, "R2 read hit w0");
      look(va(18'h0A, 8'h5, 14'h0001), 1, "R4 write to read-only");
      look(va(18'h0B, 8'h5, 14'h2222), 1, "R5 write hit");
      look(va(18'h0B, 8'h5, 14'h0003), 1, "R5 dirty seen");
      look(va(18'h0A, 8'h6, 14'h0000), 0, "R1 other set misses");
      // R8 R9: victim sequence on set 9
      look(va(18'h7, 8'h9, 14'h0), 0, "R9 both invalid");
      wr_entry(9, 0, 1, 0, 2'b11, 18'h20, 22'h1); cyc("fill 9/0");
      look(va(18'h7, 8'h9, 14'h0), 0, "R9 way1 invalid");
      wr_entry(9, 1, 1, 0, 2'b11, 18'h21, 22'h2); cyc("fill 9/1");
      look(va(18'h20, 8'h9, 14'h0), 0, "R9 refs clear use lru");
      look(va(18'h21, 8'h9, 14'h0), 0, "R9 one ref clear");
      look(va(18'h20, 8'h9, 14'h0), 0, "R8 both ref lru");
      os_clr_ref = 1; cyc("R6 clear refs");
      look(va(18'h20, 8'h9, 14'h0), 0, "R6 ref cleared");
      // R6: clear together with a hit keeps the hit's flag
      os_clr_ref = 1; look(va(18'h21, 8'h9, 14'h0), 0, "R6 clear with hit");
      look(va(18'h21, 8'h9, 14'h0), 0, "R6 flag kept");
      // R11: write over the entry being looked up
      wr_entry(5, 1, 1, 0, 2'b10, 18'h0C, 22'h00777);
      look(va(18'h0B, 8'h5, 14'h0044), 1, "R11 old contents");
      look(va(18'h0C, 8'h5, 14'h0044), 1, "R11 new entry");
      look(va(18'h0B, 8'h5, 14'h0044), 0, "R11 old tag gone");
      // R10: invalidate beats OS write
      wr_entry(12, 0, 1, 0, 2'b11, 18'h33, 22'h4);
      inv_all = 1; cyc("R10 inv with write");
      look(va(18'h33, 8'd12, 14'h0), 0, "R10 write dropped");
      look(va(18'h20, 8'h9, 14'h0), 0, "R10 all invalid");
      // random phase: tag bit0 equals way, so tags never repeat within a set
      for (int n = 0; n < 3000; n++) begin
         int r;
         r = int'($urandom_range(0, 99));
         if (r < 30) begin
            bit w;
            w = 1'($urandom);
            wr_entry(int'($urandom_range(0, 3)), w, ($urandom_range(0, 7) != 0),
                     1'($urandom), 2'($urandom), {15'd0, 2'($urandom), w},
                     22'($urandom));
         end
         if (r > 94) os_clr_ref = 1;
         if (r == 50) inv_all = 1;
         if (r >= 20) begin
            lk_valid = 1;
            lk_wr = 1'($urandom);
            lk_va = va({15'd0, 3'($urandom)}, 8'($urandom_range(0, 3)), 14'($urandom));
         end
         cyc("random");
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule